// File: doc/BRIEF.md
# PDM Microphone Bit Clock Generator

This block produces the bit clock for a pulse-density-modulated microphone. It picks one of two single-cycle clock-enable streams, both living in the system clock domain, and divides the chosen stream by an even ratio set by a 7-bit prescale value. A full output period lasts 2*(P+1) selected enables. The decimation filter downstream needs to know where each bit is and where each sample ends. For that the block also gives a bit-sample strobe on every rising edge of the output clock and a sample strobe once every 64 or 128 rising edges, depending on the oversampling code.

Software selects the prescale value, the source and the oversampling code, then raises the run input. A change to the prescale value or the source while the block is running waits for the next rising edge of the output clock. Every period on the wire is therefore whole and built from one setting. Dropping run parks the clock low and clears all counting state.

Top module: `mic_bitclk_gen`

## Requirements
- R1: While `run` is 0, `pdm_clk`, `bit_strobe` and `sample_strobe` are 0 from the next cycle on, and the divider and edge counters are cleared so the next run starts from a fresh period and a fresh frame.
- R2: While running with prescale value P, `pdm_clk` stays high for exactly P+1 selected enables and low for exactly P+1 selected enables, so one period spans 2*(P+1) enables.
- R3: `src_sel` = 0 selects `src_ticks[0]` and `src_sel` = 1 selects `src_ticks[1]`; the unselected enable has no effect on `pdm_clk`.
- R4: `bit_strobe` is high for exactly one cycle, in the first cycle that `pdm_clk` is high after being low, and at no other time.
- R5: The oversampling code `osr_code` (3 bits) selects the frame length: code 1 gives 64 rising edges, code 0 and every other code give 128. The code is captured while `run` is 0 and again at each sample strobe.
- R6: `sample_strobe` is high only together with `bit_strobe`, on the Nth rising edge counted from the start of the run and every Nth one after that.
- R7: A change of `prescale` or `src_sel` while running takes effect at the next rising edge of `pdm_clk`; each period, rise to rise, uses a single setting and has a high time of exactly half of it.
- R8: The extremes of the prescale range work: P = 0 toggles `pdm_clk` on every selected enable, and P = 127 gives a period of 256 enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run enable; 0 parks the clock and clears the counters |
| src_ticks | input | 2 | Clock-enable pulses of the two candidate sources |
| src_sel | input | 1 | Source select: 0 picks bit 0, 1 picks bit 1 |
| prescale | input | 7 | Prescale value P; period is 2*(P+1) enables |
| osr_code | input | 3 | Oversampling code: 1 means 64, all others mean 128 |
| pdm_clk | output | 1 | Microphone bit clock |
| bit_strobe | output | 1 | One-cycle pulse in the first high cycle of `pdm_clk` |
| sample_strobe | output | 1 | One-cycle pulse closing each frame of 64 or 128 bits |

## Verification
A divider counter that has drifted past its limit or been loaded from the wrong source shows up at the very next half period. It appears as a high or low phase of the wrong length, measured in system cycles against the known spacing of each source's enables. A corrupted edge counter or a wrongly decoded oversampling code is only visible at the end of the first frame, up to 128 output periods after the run starts, as a sample strobe that lands on the wrong rising edge. A setting that was applied in the middle of a period shows up within one period as a rise-to-rise interval whose high time is not half of it.

// File: rtl/pdmck_pkg.sv
package pdmck_pkg;
  localparam int unsigned RATIO_W = 8;

  // Number of bit clocks per output sample for an oversampling code.
  function automatic logic [RATIO_W-1:0] osr_ratio(input logic [2:0] code);
    return (code == 3'd1) ? RATIO_W'(64) : RATIO_W'(128);
  endfunction

  // Selected-source enables in one half of the bit clock.
  function automatic int unsigned half_ticks(input int unsigned presc);
    return presc + 1;
  endfunction
endpackage

// File: rtl/pdmck_src_mux.sv
module pdmck_src_mux #(
  parameter int NSRC  = 2,
  parameter int SEL_W = 1
) (
  input  logic [NSRC-1:0]  ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = ticks[g] & (sel == SEL_W'(g));
  end

  assign tick = |hit;
endmodule

// File: rtl/pdmck_halfdiv.sv
module pdmck_halfdiv #(
  parameter int PRESC_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [PRESC_W-1:0] limit,
  output logic               pdm_clk,
  output logic               rise_evt,
  output logic               fall_evt,
  output logic [PRESC_W-1:0] cnt
);
  logic [PRESC_W-1:0] cnt_q;
  logic               clk_q;
  logic               step;
  logic               at_lim;

  assign step     = run & tick;
  assign at_lim   = (cnt_q == limit);
  assign rise_evt = step & at_lim & ~clk_q;
  assign fall_evt = step & at_lim & clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (step) begin
      if (at_lim) begin
        cnt_q <= '0;
        clk_q <= ~clk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pdm_clk = clk_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/pdmck_framer.sv
module pdmck_framer
  import pdmck_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rise_evt,
  input  logic [2:0] code,
  output logic       frame_evt
);
  logic [CNT_W-1:0]   rcnt_q;
  logic [RATIO_W-1:0] ratio;
  logic               last;

  assign ratio     = osr_ratio(code);
  assign last      = ({1'b0, rcnt_q} == (ratio - 1'b1));
  assign frame_evt = run & rise_evt & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
    end else if (!run) begin
      rcnt_q <= '0;
    end else if (rise_evt) begin
      rcnt_q <= last ? '0 : rcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mic_bitclk_gen.sv
module mic_bitclk_gen
  import pdmck_pkg::*;
#(
  parameter int PRESC_W = 7,
  parameter int NSRC    = 2,
  parameter int OSR_W   = 3,
  parameter int SEL_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NSRC-1:0]    src_ticks,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [PRESC_W-1:0] prescale,
  input  logic [OSR_W-1:0]   osr_code,
  output logic               pdm_clk,
  output logic               bit_strobe,
  output logic               sample_strobe
);
  localparam int FRAME_CNT_W = RATIO_W - 1;

  // Active settings, reloaded only while idle or at a boundary.
  logic [PRESC_W-1:0] presc_act;
  logic [SEL_W-1:0]   sel_act;
  logic [2:0]         osr_act;

  logic               sel_tick;
  logic               rise_evt;
  logic               fall_evt;
  logic               frame_evt;
  logic [PRESC_W-1:0] div_cnt;
  logic               bit_q;
  logic               frame_q;

  pdmck_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .ticks (src_ticks),
    .sel   (sel_act),
    .tick  (sel_tick)
  );

  pdmck_halfdiv #(.PRESC_W(PRESC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (sel_tick),
    .limit    (presc_act),
    .pdm_clk  (pdm_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .cnt      (div_cnt)
  );

  pdmck_framer #(.CNT_W(FRAME_CNT_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .rise_evt  (rise_evt),
    .code      (osr_act),
    .frame_evt (frame_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_act <= '0;
      sel_act   <= '0;
    end else if (!run || rise_evt) begin
      presc_act <= prescale;
      sel_act   <= src_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osr_act <= '0;
    end else if (!run || frame_evt) begin
      osr_act <= 3'(osr_code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      bit_q   <= run & rise_evt;
      frame_q <= run & frame_evt;
    end
  end

  assign bit_strobe    = bit_q;
  assign sample_strobe = frame_q;
endmodule

// File: rtl/mic_bitclk_chk.sv
module mic_bitclk_chk #(
  parameter int PRESC_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               sel_tick,
  input logic               rise_evt,
  input logic [PRESC_W-1:0] presc_act,
  input logic [PRESC_W-1:0] div_cnt,
  input logic               pdm_clk,
  input logic               bit_strobe,
  input logic               sample_strobe
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pdm_clk && !bit_strobe && !sample_strobe));

  // R4
  strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> (pdm_clk && !$past(pdm_clk)));

  // R4
  rise_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdm_clk) |-> bit_strobe);

  // R6
  frame_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> bit_strobe);

  // R3
  toggle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (pdm_clk != $past(pdm_clk))) |-> $past(sel_tick));

  // R7
  setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(rise_evt)) |-> $stable(presc_act));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_cnt <= presc_act));
endmodule

bind mic_bitclk_gen mic_bitclk_chk #(.PRESC_W(PRESC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run           (run),
  .sel_tick      (sel_tick),
  .rise_evt      (rise_evt),
  .presc_act     (presc_act),
  .div_cnt       (div_cnt),
  .pdm_clk       (pdm_clk),
  .bit_strobe    (bit_strobe),
  .sample_strobe (sample_strobe)
);

// File: tb/mic_bitclk_gen_bench.sv
`timescale 1ns/1ps
module mic_bitclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       tick_a = 1'b0;
  logic       tick_b = 1'b0;
  logic       src_sel = 1'b0;
  logic [6:0] prescale = '0;
  logic [2:0] osr_code = '0;
  logic       pdm_clk, bit_strobe, sample_strobe;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  int pa = 0;
  int pb = 0;

  always #5 clk = ~clk;

  mic_bitclk_gen u_mic_bitclk_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .src_ticks     ({tick_b, tick_a}),
    .src_sel       (src_sel),
    .prescale      (prescale),
    .osr_code      (osr_code),
    .pdm_clk       (pdm_clk),
    .bit_strobe    (bit_strobe),
    .sample_strobe (sample_strobe)
  );

  // Source 0 fires every 2 cycles, source 1 every 3 cycles.
  always @(negedge clk) begin
    pa     = (pa + 1) % 2;
    pb     = (pb + 1) % 3;
    tick_a <= (pa == 0);
    tick_b <= (pb == 0);
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", wd);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input int code);
    return (code == 1) ? 64 : 128;
  endfunction

  // Run one setting; measure periods, halves, strobes and frame length.
  task automatic run_cfg(input int p, input int sel, input int code,
                         input bit want_frame, input int n_rises);
    int stride = sel ? 3 : 2;
    int period = 2 * (p + 1) * stride;
    int ratio  = ratio_of(code);
    int cyc = 0, last = -1, nr = 0, lim;
    bit prev = 1'b0, done = 1'b0;
    string rq = sel ? "R3/R2" : "R2";
    if (p == 0 || p == 127) rq = "R8";
    lim = want_frame ? period * (ratio + 2) : period * (n_rises + 2);
    run = 1'b0; prescale = 7'(p); src_sel = sel[0]; osr_code = 3'(code);
    repeat (3) @(negedge clk);
    check(!pdm_clk && !bit_strobe && !sample_strobe, "R1 idle outputs",
          {pdm_clk, bit_strobe, sample_strobe}, 0);
    run = 1'b1;
    while (!done && cyc < lim) begin
      @(negedge clk);
      cyc++;
      if (pdm_clk && !prev) begin
        nr++;
        check(bit_strobe, "R4 strobe on rise", bit_strobe, 1);
        if (last >= 0) check(cyc - last == period, rq, cyc - last, period);
        last = cyc;
      end else if (bit_strobe) begin
        check(1'b0, "R4 stray strobe", cyc, -1);
      end
      if (!pdm_clk && prev && last >= 0)
        check(cyc - last == period / 2, {rq, " high half"}, cyc - last, period / 2);
      if (sample_strobe) begin
        check(nr == ratio, "R5 rises per frame", nr, ratio);
        check(bit_strobe, "R6 frame with bit", bit_strobe, 1);
        if (want_frame) done = 1'b1;
      end
      if (!want_frame && nr >= n_rises) done = 1'b1;
      prev = pdm_clk;
    end
    check(done, "R2 run completed", cyc, lim);
    run = 1'b0;
    @(negedge clk);
    check(!pdm_clk && !bit_strobe && !sample_strobe, "R1 after stop",
          {pdm_clk, bit_strobe, sample_strobe}, 0);
  endtask

  // Change prescale in mid-run on source 0; every period must stay whole.
  task automatic change_mid(input int p0, input int p1, input int wait_cyc);
    int per0 = 4 * (p0 + 1), per1 = 4 * (p1 + 1);
    int cyc = 0, last = -1, fallc = -1, nr = 0, per = 0;
    bit prev = 1'b0;
    run = 1'b0; prescale = 7'(p0); src_sel = 1'b0; osr_code = 3'd0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    while (nr < 8 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == wait_cyc) prescale = 7'(p1);
      if (!pdm_clk && prev) fallc = cyc;
      if (pdm_clk && !prev) begin
        nr++;
        if (last >= 0) begin
          per = cyc - last;
          check(per == per0 || per == per1, "R7 whole period", per, per1);
          check(2 * (fallc - last) == per, "R7 half high", fallc - last, per / 2);
        end
        last = cyc;
      end
      prev = pdm_clk;
    end
    check(per == per1, "R7 new setting used", per, per1);
    run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!pdm_clk && !bit_strobe && !sample_strobe, "R1 reset state",
          {pdm_clk, bit_strobe, sample_strobe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R5, R6 sweep: small prescales, both sources, every code class
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 4; c++)
          run_cfg(p, s, c, 1'b1, 0);
    // R2, R3: further prescales on both sources
    for (int p = 4; p < 10; p++)
      for (int s = 0; s < 2; s++)
        run_cfg(p, s, 0, 1'b0, 4);
    // R8: top of the range
    run_cfg(127, 0, 1, 1'b0, 3);
    // R7: mid-run changes, growing and shrinking, early and late in a period
    change_mid(3, 1, 21);
    change_mid(3, 1, 26);
    change_mid(1, 5, 13);
    change_mid(6, 0, 40);
    summary();
    $finish;
  end
endmodule